// File: doc/BRIEF.md
# USB Device OUT/SETUP Receive Buffer Writer

This block handles the data phase of an OUT or SETUP transaction on the device side of a full-speed USB interface. Once the token decoder has matched an endpoint, it presents that endpoint's receive status and buffer descriptor on a one-cycle token strobe. The block then takes the incoming payload bytes and packs them into half-words for a 16-bit packet memory, which is byte-addressed. When the packet closes it picks the handshake the bus interface should send.

The write address is loaded from the descriptor. The space available is worked out from the descriptor's block-size bit and block count. Writes never go past that space. A payload that does not fit is refused with STALL. A damaged packet raises an error flag and gets no handshake. A clean packet is acknowledged, and its byte count is written back into the descriptor word.

Top module: `usb_out_rxbuf`

## Requirements
- R1: A `tok_valid` strobe with `ep_stat` = 3 (valid) starts a reception: the first half-word is written at `desc_base`, and the received count restarts at zero.
- R2: The allocated space in bytes is `desc_nblk`×2 when `desc_big` = 0 and `desc_nblk`×32 when `desc_big` = 1.
- R3: Bytes are packed little-endian. The first byte of each pair goes to `mem_wdata[7:0]` and the second to `mem_wdata[15:8]`, with `mem_be` = 2'b11. When the packet ends on an odd byte, that byte is written alone in bits 7:0, with bits 15:8 zero and `mem_be` = 2'b01. `mem_be` = 2'b10 never occurs.
- R4: Each full half-word write advances the byte address by 2.
- R5: Once the allocated space is used, further bytes produce no memory write.
- R6: A payload longer than the allocated space ends in STALL (`hs_code` = 3), with no `err_irq` and no count write-back.
- R7: ACK (`hs_code` = 1) is given only when `eop` arrives with `crc_ok` = 1, no line error and no overrun. It appears in the cycle after `eop`.
- R8: A bad CRC at `eop`, or `line_err` during the packet, gives no handshake and a one-cycle `err_irq` pulse. A pending odd byte is still written. The block then accepts the next token.
- R9: A token with `ep_stat` = 2 gives NAK (`hs_code` = 2) and one with `ep_stat` = 1 gives STALL in the next cycle. `ep_stat` = 0 gives no handshake. None of these writes memory.
- R10: After an ACK, `cnt_we` pulses in the same cycle. `cnt_ep` carries the endpoint and `cnt_data` = {block-size bit [15], block count [14:10], received byte count [9:0]}, with the two descriptor fields unchanged.
- R11: Payload bytes, `eop` and `line_err` are ignored while no reception is open, and every output is registered one clock after its cause.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_valid | input | 1 | Data phase begins for the matched endpoint |
| tok_ep | input | 4 | Matched endpoint number |
| ep_stat | input | 2 | Receive status: 0 off, 1 stall, 2 nak, 3 valid |
| desc_base | input | 16 | Buffer start byte address |
| desc_big | input | 1 | Block size select: 0 = 2 bytes, 1 = 32 bytes |
| desc_nblk | input | 5 | Number of blocks |
| byte_valid | input | 1 | Payload byte strobe |
| byte_data | input | 8 | Payload byte |
| eop | input | 1 | End of data packet |
| crc_ok | input | 1 | CRC result, valid with eop |
| line_err | input | 1 | Bit-stuff or framing error |
| mem_we | output | 1 | Packet memory write |
| mem_addr | output | 16 | Byte address of the half-word |
| mem_wdata | output | 16 | Half-word data |
| mem_be | output | 2 | Byte enables |
| hs_valid | output | 1 | Handshake request |
| hs_code | output | 2 | 1 ACK, 2 NAK, 3 STALL |
| err_irq | output | 1 | Reception error flag pulse |
| cnt_we | output | 1 | Descriptor count write-back |
| cnt_ep | output | 4 | Endpoint of the write-back |
| cnt_data | output | 16 | Write-back descriptor word |

## Verification
The assertions watch relations that must hold in every cycle. An ACK always follows a good-CRC end of packet. A count write-back happens only with an ACK. An error pulse never comes with a handshake. A NAK never comes with a memory write. The byte enables are never high-only, and a lone low-byte write is always the last write of its packet. The bench's scenarios are what show the bound and the values: writes stop exactly at the allocated size for both block sizes, the half-words land at the expected addresses in little-endian order, the count and descriptor fields are returned correctly, zero-length and exactly-full packets are handled, and the block recovers after an error.

// File: rtl/usb_rxbuf_pkg.sv
package usb_rxbuf_pkg;

    localparam int ADDR_W = 16;
    localparam int NBLK_W = 5;
    localparam int CNT_W  = 10;
    localparam int REM_W  = 16;
    localparam int DW     = 16;
    localparam int BE_W   = DW / 8;
    localparam int SMALL_SHIFT = 1;   // 2-byte blocks
    localparam int LARGE_SHIFT = 5;   // 32-byte blocks

    typedef enum logic [1:0] {
        HS_NONE  = 2'd0,
        HS_ACK   = 2'd1,
        HS_NAK   = 2'd2,
        HS_STALL = 2'd3
    } hs_e;

    typedef enum logic [1:0] {
        EPS_OFF   = 2'd0,
        EPS_STALL = 2'd1,
        EPS_NAK   = 2'd2,
        EPS_VALID = 2'd3
    } ep_stat_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } rx_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        logic              big;
        logic [NBLK_W-1:0] nblk;
    } rxdesc_t;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DW-1:0]     data;
        logic [BE_W-1:0]   be;
    } memwr_t;

    // Bytes available in the buffer described by the descriptor.
    function automatic logic [REM_W-1:0] alloc_bytes(input logic big,
                                                     input logic [NBLK_W-1:0] nblk);
        logic [REM_W-1:0] n;
        n = REM_W'(nblk);
        return big ? (n << LARGE_SHIFT) : (n << SMALL_SHIFT);
    endfunction

    // Descriptor word returned on a clean ACK.
    function automatic logic [DW-1:0] pack_count(input logic big,
                                                 input logic [NBLK_W-1:0] nblk,
                                                 input logic [CNT_W-1:0] cnt);
        return {big, nblk, cnt};
    endfunction

endpackage

// File: rtl/usb_rxbuf_space.sv
module usb_rxbuf_space
    import usb_rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [REM_W-1:0] alloc,
    input  logic             step,
    output logic             room,
    output logic [CNT_W-1:0] rcv_cnt
);
    logic [REM_W-1:0] rem_q;
    logic [CNT_W-1:0] cnt_q;

    assign room    = (rem_q != '0);
    assign rcv_cnt = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q <= '0;
            cnt_q <= '0;
        end else if (load) begin
            rem_q <= alloc;
            cnt_q <= '0;
        end else if (step) begin
            cnt_q <= cnt_q + 1'b1;
            if (room)
                rem_q <= rem_q - 1'b1;
        end
    end
endmodule

// File: rtl/usb_rxbuf_packer.sv
module usb_rxbuf_packer
    import usb_rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] base,
    input  logic              push,
    input  logic [7:0]        din,
    input  logic              flush,
    output memwr_t            wr
);
    logic [7:0]        hold_q;
    logic              have_q;
    logic [ADDR_W-1:0] addr_q;
    memwr_t            wr_q;

    assign wr = wr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
            have_q <= 1'b0;
            addr_q <= '0;
            wr_q   <= '0;
        end else begin
            wr_q.we <= 1'b0;
            if (load) begin
                addr_q <= base;
                have_q <= 1'b0;
            end else if (push) begin
                if (have_q) begin
                    wr_q.we   <= 1'b1;
                    wr_q.addr <= addr_q;
                    wr_q.data <= {din, hold_q};
                    wr_q.be   <= 2'b11;
                    addr_q    <= addr_q + ADDR_W'(BE_W);
                    have_q    <= 1'b0;
                end else begin
                    hold_q <= din;
                    have_q <= 1'b1;
                end
            end else if (flush && have_q) begin
                wr_q.we   <= 1'b1;
                wr_q.addr <= addr_q;
                wr_q.data <= {8'h00, hold_q};
                wr_q.be   <= 2'b01;
                have_q    <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/usb_rxbuf_ctrl.sv
module usb_rxbuf_ctrl
    import usb_rxbuf_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tok_valid,
    input  logic [EP_W-1:0]  tok_ep,
    input  ep_stat_e         ep_stat,
    input  rxdesc_t          desc,
    input  logic             byte_valid,
    input  logic             eop,
    input  logic             crc_ok,
    input  logic             line_err,
    input  logic             room,
    input  logic [CNT_W-1:0] rcv_cnt,
    output logic             load,
    output logic             step,
    output logic             push,
    output logic             flush,
    output logic             hs_valid,
    output hs_e              hs_code,
    output logic             err_irq,
    output logic             cnt_we,
    output logic [EP_W-1:0]  cnt_ep,
    output logic [DW-1:0]    cnt_data
);
    rx_state_e         state_q;
    logic              ovr_q;
    logic [EP_W-1:0]   ep_q;
    logic              big_q;
    logic [NBLK_W-1:0] nblk_q;
    logic              in_rx;
    logic              closing;

    assign in_rx   = (state_q == ST_RECV);
    assign closing = in_rx && (eop || line_err);
    assign load    = (state_q == ST_IDLE) && tok_valid && (ep_stat == EPS_VALID);
    assign step    = in_rx && byte_valid && !closing;
    assign push    = step && room;
    assign flush   = closing;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            ovr_q    <= 1'b0;
            ep_q     <= '0;
            big_q    <= 1'b0;
            nblk_q   <= '0;
            hs_valid <= 1'b0;
            hs_code  <= HS_NONE;
            err_irq  <= 1'b0;
            cnt_we   <= 1'b0;
            cnt_ep   <= '0;
            cnt_data <= '0;
        end else begin
            hs_valid <= 1'b0;
            err_irq  <= 1'b0;
            cnt_we   <= 1'b0;
            if (state_q == ST_IDLE) begin
                if (tok_valid) begin
                    unique case (ep_stat)
                        EPS_VALID: begin
                            state_q <= ST_RECV;
                            ovr_q   <= 1'b0;
                            ep_q    <= tok_ep;
                            big_q   <= desc.big;
                            nblk_q  <= desc.nblk;
                        end
                        EPS_NAK: begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_NAK;
                        end
                        EPS_STALL: begin
                            hs_valid <= 1'b1;
                            hs_code  <= HS_STALL;
                        end
                        default: ;
                    endcase
                end
            end else begin
                if (line_err) begin
                    err_irq <= 1'b1;
                    state_q <= ST_IDLE;
                end else if (eop) begin
                    state_q <= ST_IDLE;
                    if (!crc_ok) begin
                        err_irq <= 1'b1;
                    end else if (ovr_q) begin
                        hs_valid <= 1'b1;
                        hs_code  <= HS_STALL;
                    end else begin
                        hs_valid <= 1'b1;
                        hs_code  <= HS_ACK;
                        cnt_we   <= 1'b1;
                        cnt_ep   <= ep_q;
                        cnt_data <= pack_count(big_q, nblk_q, rcv_cnt);
                    end
                end else if (byte_valid && !room) begin
                    ovr_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/usb_out_rxbuf.sv
module usb_out_rxbuf
    import usb_rxbuf_pkg::*;
#(
    parameter int EP_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_valid,
    input  logic [EP_W-1:0]   tok_ep,
    input  logic [1:0]        ep_stat,
    input  logic [ADDR_W-1:0] desc_base,
    input  logic              desc_big,
    input  logic [NBLK_W-1:0] desc_nblk,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              eop,
    input  logic              crc_ok,
    input  logic              line_err,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DW-1:0]     mem_wdata,
    output logic [BE_W-1:0]   mem_be,
    output logic              hs_valid,
    output logic [1:0]        hs_code,
    output logic              err_irq,
    output logic              cnt_we,
    output logic [EP_W-1:0]   cnt_ep,
    output logic [DW-1:0]     cnt_data
);
    rxdesc_t          desc;
    memwr_t           wr;
    hs_e              hs;
    logic             load, step, push, flush, room;
    logic [CNT_W-1:0] rcv_cnt;

    assign desc = '{base: desc_base, big: desc_big, nblk: desc_nblk};

    usb_rxbuf_ctrl #(.EP_W(EP_W)) ctrl_i (
        .clk        (clk),
        .rst        (rst),
        .tok_valid  (tok_valid),
        .tok_ep     (tok_ep),
        .ep_stat    (ep_stat_e'(ep_stat)),
        .desc       (desc),
        .byte_valid (byte_valid),
        .eop        (eop),
        .crc_ok     (crc_ok),
        .line_err   (line_err),
        .room       (room),
        .rcv_cnt    (rcv_cnt),
        .load       (load),
        .step       (step),
        .push       (push),
        .flush      (flush),
        .hs_valid   (hs_valid),
        .hs_code    (hs),
        .err_irq    (err_irq),
        .cnt_we     (cnt_we),
        .cnt_ep     (cnt_ep),
        .cnt_data   (cnt_data)
    );

    usb_rxbuf_space space_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .alloc   (alloc_bytes(desc_big, desc_nblk)),
        .step    (step),
        .room    (room),
        .rcv_cnt (rcv_cnt)
    );

    usb_rxbuf_packer packer_i (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .base  (desc_base),
        .push  (push),
        .din   (byte_data),
        .flush (flush),
        .wr    (wr)
    );

    assign hs_code   = hs;
    assign mem_we    = wr.we;
    assign mem_addr  = wr.addr;
    assign mem_wdata = wr.data;
    assign mem_be    = wr.be;
endmodule

// File: rtl/usb_rxbuf_chk.sv
module usb_rxbuf_chk (
    input logic       clk,
    input logic       rst,
    input logic       tok_valid,
    input logic [1:0] ep_stat,
    input logic       eop,
    input logic       crc_ok,
    input logic       mem_we,
    input logic [1:0] mem_be,
    input logic       hs_valid,
    input logic [1:0] hs_code,
    input logic       err_irq,
    input logic       cnt_we
);
    // R7
    ack_after_good_eop_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd1) |-> $past(eop && crc_ok));

    // R10
    wb_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |-> (hs_valid && hs_code == 2'd1));

    // R8
    err_without_hs_chk: assert property (@(posedge clk) disable iff (rst)
        err_irq |-> !hs_valid);

    // R9
    nak_from_token_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_valid && hs_code == 2'd2) |-> ($past(tok_valid && ep_stat == 2'd2) && !mem_we));

    // R3
    be_shape_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (mem_be == 2'b11 || mem_be == 2'b01));

    // R3
    tail_is_last_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_we && mem_be == 2'b01) |=> !mem_we);
endmodule

bind usb_out_rxbuf usb_rxbuf_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .tok_valid (tok_valid),
    .ep_stat   (ep_stat),
    .eop       (eop),
    .crc_ok    (crc_ok),
    .mem_we    (mem_we),
    .mem_be    (mem_be),
    .hs_valid  (hs_valid),
    .hs_code   (hs_code),
    .err_irq   (err_irq),
    .cnt_we    (cnt_we)
);

// File: tb/usb_out_rxbuf_tb_top.sv
module usb_out_rxbuf_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tok_valid = 1'b0;
    logic [3:0]  tok_ep = '0;
    logic [1:0]  ep_stat = '0;
    logic [15:0] desc_base = '0;
    logic        desc_big = 1'b0;
    logic [4:0]  desc_nblk = '0;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        eop = 1'b0;
    logic        crc_ok = 1'b0;
    logic        line_err = 1'b0;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [1:0]  mem_be;
    logic        hs_valid;
    logic [1:0]  hs_code;
    logic        err_irq;
    logic        cnt_we;
    logic [3:0]  cnt_ep;
    logic [15:0] cnt_data;

    always #5 clk = ~clk;

    usb_out_rxbuf dut_i (.*);

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_busy, m_ovr;
    int m_addr, m_rem, m_cnt, m_hold, m_ep, m_big, m_nblk;
    bit e_we, e_hs_v, e_irq, e_cnt_we;
    int e_addr, e_data, e_be, e_hs, e_cnt_ep, e_cnt_data;

    task automatic m_flush();
        if (m_hold >= 0) begin
            e_we = 1; e_addr = m_addr; e_data = m_hold; e_be = 1;
            m_hold = -1;
        end
    endtask

    always @(posedge clk) begin
        e_we = 0; e_hs_v = 0; e_irq = 0; e_cnt_we = 0;
        if (rst) begin
            m_busy = 0; m_hold = -1; m_ovr = 0;
        end else if (!m_busy) begin
            if (tok_valid) begin
                if (ep_stat == 3) begin
                    m_busy = 1; m_addr = desc_base; m_cnt = 0; m_hold = -1; m_ovr = 0;
                    m_big = desc_big; m_nblk = desc_nblk; m_ep = tok_ep;
                    m_rem = desc_big ? desc_nblk * 32 : desc_nblk * 2;
                end else if (ep_stat == 2) begin
                    e_hs_v = 1; e_hs = 2;
                end else if (ep_stat == 1) begin
                    e_hs_v = 1; e_hs = 3;
                end
            end
        end else if (line_err) begin
            m_flush(); e_irq = 1; m_busy = 0;
        end else if (eop) begin
            m_flush(); m_busy = 0;
            if (!crc_ok) e_irq = 1;
            else if (m_ovr) begin e_hs_v = 1; e_hs = 3; end
            else begin
                e_hs_v = 1; e_hs = 1; e_cnt_we = 1; e_cnt_ep = m_ep;
                e_cnt_data = (m_big << 15) | (m_nblk << 10) | (m_cnt & 1023);
            end
        end else if (byte_valid) begin
            m_cnt++;
            if (m_rem == 0) m_ovr = 1;
            else begin
                m_rem--;
                if (m_hold < 0) m_hold = byte_data;
                else begin
                    e_we = 1; e_addr = m_addr; e_data = (byte_data << 8) | m_hold; e_be = 3;
                    m_addr += 2; m_hold = -1;
                end
            end
        end
    end

    // ---------------- every-cycle comparison + memory image ----------------
    logic [7:0] bmem [int];
    int wr_count = 0;

    always @(negedge clk) begin
        if (!done) begin
            chk(mem_we == e_we, "R5", "mem_we", mem_we, e_we);
            if (mem_we && e_we) begin
                chk(mem_addr == e_addr[15:0], "R4", "mem_addr", mem_addr, e_addr);
                chk(mem_wdata == e_data[15:0], "R3", "mem_wdata", mem_wdata, e_data);
                chk(mem_be == e_be[1:0], "R3", "mem_be", mem_be, e_be);
            end
            chk(hs_valid == e_hs_v, "R7", "hs_valid", hs_valid, e_hs_v);
            if (hs_valid && e_hs_v)
                chk(hs_code == e_hs[1:0], "R9", "hs_code", hs_code, e_hs);
            chk(err_irq == e_irq, "R8", "err_irq", err_irq, e_irq);
            chk(cnt_we == e_cnt_we, "R10", "cnt_we", cnt_we, e_cnt_we);
            if (cnt_we && e_cnt_we) begin
                chk(cnt_ep == e_cnt_ep[3:0], "R10", "cnt_ep", cnt_ep, e_cnt_ep);
                chk(cnt_data == e_cnt_data[15:0], "R10", "cnt_data", cnt_data, e_cnt_data);
            end
            if (mem_we) begin
                wr_count++;
                if (mem_be[0]) bmem[int'(mem_addr)]     = mem_wdata[7:0];
                if (mem_be[1]) bmem[int'(mem_addr) + 1] = mem_wdata[15:8];
            end
        end
    end

    // ---------------- stimulus ----------------
    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 13 + i * 37 + 5) & 255);
    endfunction

    task automatic token(input int ep, input int st, input int base, input bit big, input int nb);
        @(negedge clk);
        tok_valid = 1; tok_ep = 4'(ep); ep_stat = 2'(st);
        desc_base = 16'(base); desc_big = big; desc_nblk = 5'(nb);
        @(negedge clk);
        tok_valid = 0;
    endtask

    task automatic send(input int n, input int seed);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            byte_valid = 1; byte_data = pat(seed, i);
        end
        @(negedge clk);
        byte_valid = 0;
    endtask

    task automatic finish_pkt(input bit good);
        @(negedge clk);
        eop = 1; crc_ok = good;
        @(negedge clk);
        eop = 0; crc_ok = 0;
        repeat (2) @(negedge clk);
    endtask

    int w0;

    initial begin
        repeat (3) @(negedge clk);
        // R11: registered outputs quiet after reset
        chk(!mem_we && !hs_valid && !err_irq && !cnt_we, "R11", "reset outputs",
            {mem_we, hs_valid, err_irq, cnt_we}, 0);
        rst = 0;
        @(negedge clk);

        // R11: stray payload and eop while idle are ignored
        send(3, 9); finish_pkt(1);
        chk(wr_count == 0, "R11", "idle writes", wr_count, 0);

        // R1 R3 R4 R10: odd 5-byte packet into 8-byte buffer
        token(2, 3, 'h40, 0, 4); send(5, 1); finish_pkt(1);
        chk(bmem['h40] == pat(1, 0) && bmem['h41] == pat(1, 1), "R3", "first half-word",
            {bmem['h41], bmem['h40]}, {pat(1, 1), pat(1, 0)});
        chk(bmem['h44] == pat(1, 4), "R3", "tail byte", bmem['h44], pat(1, 4));
        chk(wr_count == 3, "R4", "write count A", wr_count, 3);

        // R2: exactly full 32-byte block
        w0 = wr_count;
        token(5, 3, 'h100, 1, 1); send(32, 2); finish_pkt(1);
        chk(wr_count - w0 == 16, "R2", "full large block writes", wr_count - w0, 16);
        chk(bmem['h11f] == pat(2, 31), "R2", "last byte of block", bmem['h11f], pat(2, 31));

        // R5 R6: overrun into 4-byte buffer
        w0 = wr_count;
        token(1, 3, 'h200, 0, 2); send(7, 3); finish_pkt(1);
        chk(wr_count - w0 == 2, "R5", "writes bounded", wr_count - w0, 2);
        chk(!bmem.exists('h204), "R5", "no write past end", bmem.exists('h204), 0);

        // R8: bad CRC after odd bytes, then line error mid-packet
        token(3, 3, 'h300, 0, 8); send(3, 4); finish_pkt(0);
        chk(bmem['h302] == pat(4, 2), "R8", "flushed byte on crc error", bmem['h302], pat(4, 2));
        token(3, 3, 'h380, 0, 8); send(3, 6);
        @(negedge clk); line_err = 1;
        @(negedge clk); line_err = 0;
        repeat (2) @(negedge clk);
        chk(bmem['h382] == pat(6, 2), "R8", "flushed byte on line error", bmem['h382], pat(6, 2));

        // R9: non-valid endpoints write nothing
        w0 = wr_count;
        token(4, 2, 'h400, 0, 4); send(2, 7); finish_pkt(1);
        token(4, 1, 'h400, 0, 4); send(2, 7); finish_pkt(1);
        token(4, 0, 'h400, 0, 4); send(2, 7); finish_pkt(1);
        chk(wr_count == w0, "R9", "writes for non-valid", wr_count - w0, 0);

        // R8 recovery and R7 zero-length packet
        token(6, 3, 'h500, 0, 1); send(1, 8); finish_pkt(1);
        chk(bmem['h500] == pat(8, 0), "R8", "ready after error", bmem['h500], pat(8, 0));
        token(7, 3, 'h600, 1, 3); finish_pkt(1);

        // R2: small-block bound with even fill then overrun by one
        w0 = wr_count;
        token(8, 3, 'h700, 0, 3); send(7, 9); finish_pkt(1);
        chk(wr_count - w0 == 3, "R2", "small block bound", wr_count - w0, 3);

        repeat (3) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL R11 watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule